// File: doc/BRIEF.md
# I2C Mid-Frame Condition Guard

This block watches the already-synchronized SCL and SDA lines of a two-wire serial bus while the local bus engine takes part in a transfer. It counts how many bits of the current nine-bit frame (eight data or address bits plus the acknowledge slot) have completed. A START or STOP that appears after the first bit of a frame has already been clocked is flagged as a bus error. The error raises an interrupt flag toward the host and places the error code 0x00 on the status byte.

The host sees a status byte, an interrupt flag and a small control register. The control register has three bits: bit 0 requests a stop, bit 1 requests a start and bit 2 enables acknowledge. When the flag is set by a bus error, the host recovers by writing the control register with the stop-request bit set and a one to the flag-clear bit. The block then clears the flag and the stop-request bit, and sends the engine back to the idle, not-addressed slave state. It also lets go of both bus lines without asking the engine to put a STOP on the bus. The rest of the engine reports its own events through a simple event/code input, and the block merges them into the same flag and status byte.

Top module: `i2c_frame_guard`

## Requirements
- R1: While the interrupt flag is clear (including just after reset), the status byte reads 0xF8.
- R2: With `active_i` high, a START (SDA falls while SCL stays high) or a STOP (SDA rises while SCL stays high) seen when 1 to 8 bits of the current frame have completed sets the interrupt flag and status 0x00. Both are visible one clock after the condition is sampled.
- R3: A START or STOP raises no error in three cases: when no frame is open, when zero bits of the frame have completed (including right after the ninth bit wraps the count), or while `active_i` is low.
- R4: A START opens a frame. The SCL fall that ends the START itself is not counted. Each later SCL fall completes one bit, and the ninth completed bit (the acknowledge slot) wraps the count to zero. Every START or STOP restarts the count, and a STOP closes the frame.
- R5: An `eng_evt_i` pulse sets the flag and loads `eng_code_i` into the status byte. A bus error in the same cycle takes precedence and loads 0x00.
- R6: A control write with `flag_w1_i` high clears the flag, and one with `flag_w1_i` low leaves it set. If a bus error or engine event arrives in the same cycle, the flag stays set and the clear has no effect.
- R7: Recovery happens when the flag is set with status 0x00 and a flag-clearing control write has bit 0 set. The flag is cleared, bit 0 of the control register reads 0, bits 1 and 2 take the written values, and `go_idle_o` pulses high for exactly one cycle.
- R8: Recovery releases both lines: `sda_drive_o` and `scl_drive_o` read 0 whatever the engine requests, until `active_i` next rises. Reset also releases both lines. At other times the drive outputs follow `sda_req_i`/`scl_req_i`.
- R9: Recovery never pulses `stop_gen_o`. A flag-clearing write with bit 0 set while the status is not 0x00 pulses `stop_gen_o` for one cycle instead, and does not pulse `go_idle_o`.
- R10: Reset clears the flag and the control register, and drives `go_idle_o` and `stop_gen_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| active_i | input | 1 | Engine is taking part in a transfer |
| sda_req_i | input | 1 | Engine request to pull SDA low |
| scl_req_i | input | 1 | Engine request to pull SCL low |
| eng_evt_i | input | 1 | Engine event pulse that sets the flag |
| eng_code_i | input | 8 | Status code for the engine event |
| ctl_wr_i | input | 1 | Host write strobe for control register |
| ctl_wdata_i | input | 3 | Control write data (bit0 stop req, bit1 start req, bit2 ack enable) |
| flag_w1_i | input | 1 | Flag-clear bit of the same write (1 clears) |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt flag |
| ctl_o | output | 3 | Control register contents |
| sda_drive_o | output | 1 | Pull SDA low (1) or release (0) |
| scl_drive_o | output | 1 | Pull SCL low (1) or release (0) |
| go_idle_o | output | 1 | One-cycle pulse: return engine to not-addressed idle |
| stop_gen_o | output | 1 | One-cycle pulse: engine should transmit a STOP |

## Verification
The assertions assume that SCL and SDA never change in the same clock cycle, and that each bus level lasts at least one clock. Under these conditions every START, STOP and SCL fall appears as a single-cycle event. The bench changes only one line per step and holds each level for two clocks. It changes SDA only while SCL is low, except when it deliberately creates a START or STOP. Host writes and engine events are single-cycle pulses driven between clock edges, so the precedence case is reached by lining a write up with the cycle in which a condition is sampled.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;
    localparam int          STAT_W     = 8;
    localparam logic [7:0]  ST_NONE    = 8'hF8;
    localparam logic [7:0]  ST_BUSERR  = 8'h00;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.scl = scl_i;
        st_d.sda = sda_i;
        start_o    = st_q.sda & ~sda_i & st_q.scl & scl_i;
        stop_o     = ~st_q.sda & sda_i & st_q.scl & scl_i;
        scl_fall_o = st_q.scl & ~scl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/i2c_bit_tracker.sv
module i2c_bit_tracker #(
    parameter int FRAME_BITS = 9,
    localparam int POS_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             scl_fall_i,
    output logic             mid_frame_o,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             open;
        logic             skip;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.open = 1'b1;
            st_d.skip = 1'b1;
            st_d.pos  = '0;
        end else if (stop_i) begin
            st_d.open = 1'b0;
            st_d.skip = 1'b0;
            st_d.pos  = '0;
        end else if (scl_fall_i && st_q.open) begin
            if (st_q.skip) begin
                st_d.skip = 1'b0;
            end else if (st_q.pos == LAST) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        mid_frame_o = st_q.open && (st_q.pos != '0);
        pos_o       = st_q.pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/i2c_host_ctl.sv
module i2c_host_ctl
    import i2c_guard_pkg::*;
#(
    parameter int CTL_W    = 3,
    parameter int STOP_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_err_i,
    input  logic              active_i,
    input  logic              eng_evt_i,
    input  logic [STAT_W-1:0] eng_code_i,
    input  logic              ctl_wr_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    input  logic              flag_w1_i,
    input  logic              sda_req_i,
    input  logic              scl_req_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              sda_drive_o,
    output logic              scl_drive_o,
    output logic              go_idle_o,
    output logic              stop_gen_o
);
    typedef struct packed {
        logic              flag;
        logic [STAT_W-1:0] code;
        logic [CTL_W-1:0]  ctl;
        logic              rel;
        logic              act;
        logic              go_idle;
        logic              stop_gen;
    } host_t;

    host_t st_d, st_q;
    logic  clr;

    always_comb begin
        st_d          = st_q;
        st_d.go_idle  = 1'b0;
        st_d.stop_gen = 1'b0;
        st_d.act      = active_i;
        clr = ctl_wr_i && flag_w1_i && st_q.flag && !bus_err_i && !eng_evt_i;

        if (active_i && !st_q.act) begin
            st_d.rel = 1'b0;
        end
        if (ctl_wr_i) begin
            st_d.ctl = ctl_wdata_i;
        end
        if (clr) begin
            st_d.flag = 1'b0;
            if (ctl_wdata_i[STOP_IDX]) begin
                if (st_q.code == ST_BUSERR) begin
                    st_d.ctl[STOP_IDX] = 1'b0;
                    st_d.go_idle       = 1'b1;
                    st_d.rel           = 1'b1;
                end else begin
                    st_d.stop_gen = 1'b1;
                end
            end
        end
        if (bus_err_i) begin
            st_d.flag = 1'b1;
            st_d.code = ST_BUSERR;
        end else if (eng_evt_i) begin
            st_d.flag = 1'b1;
            st_d.code = eng_code_i;
        end

        status_o    = st_q.flag ? st_q.code : ST_NONE;
        irq_o       = st_q.flag;
        ctl_o       = st_q.ctl;
        sda_drive_o = sda_req_i && !st_q.rel;
        scl_drive_o = scl_req_i && !st_q.rel;
        go_idle_o   = st_q.go_idle;
        stop_gen_o  = st_q.stop_gen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= ST_NONE;
            st_q.rel  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/i2c_frame_guard.sv
module i2c_frame_guard
    import i2c_guard_pkg::*;
#(
    parameter int CTL_W      = 3,
    parameter int STOP_IDX   = 0,
    parameter int FRAME_BITS = 9,
    localparam int POS_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              active_i,
    input  logic              sda_req_i,
    input  logic              scl_req_i,
    input  logic              eng_evt_i,
    input  logic [STAT_W-1:0] eng_code_i,
    input  logic              ctl_wr_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    input  logic              flag_w1_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              sda_drive_o,
    output logic              scl_drive_o,
    output logic              go_idle_o,
    output logic              stop_gen_o
);
    logic             cond_start, cond_stop, cond_any, scl_fall;
    logic             mid_frame, bus_err;
    logic [POS_W-1:0] bit_pos;

    i2c_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .start_o    (cond_start),
        .stop_o     (cond_stop),
        .scl_fall_o (scl_fall)
    );

    i2c_bit_tracker #(.FRAME_BITS(FRAME_BITS)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (cond_start),
        .stop_i      (cond_stop),
        .scl_fall_i  (scl_fall),
        .mid_frame_o (mid_frame),
        .pos_o       (bit_pos)
    );

    assign cond_any = cond_start | cond_stop;
    assign bus_err  = cond_any & mid_frame & active_i;

    i2c_host_ctl #(.CTL_W(CTL_W), .STOP_IDX(STOP_IDX)) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_err_i   (bus_err),
        .active_i    (active_i),
        .eng_evt_i   (eng_evt_i),
        .eng_code_i  (eng_code_i),
        .ctl_wr_i    (ctl_wr_i),
        .ctl_wdata_i (ctl_wdata_i),
        .flag_w1_i   (flag_w1_i),
        .sda_req_i   (sda_req_i),
        .scl_req_i   (scl_req_i),
        .status_o    (status_o),
        .irq_o       (irq_o),
        .ctl_o       (ctl_o),
        .sda_drive_o (sda_drive_o),
        .scl_drive_o (scl_drive_o),
        .go_idle_o   (go_idle_o),
        .stop_gen_o  (stop_gen_o)
    );
endmodule

// File: rtl/i2c_frame_guard_chk.sv
module i2c_frame_guard_chk #(
    parameter int CTL_W      = 3,
    parameter int STOP_IDX   = 0,
    parameter int FRAME_BITS = 9,
    parameter int POS_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active_i,
    input logic             cond_any,
    input logic             mid_frame,
    input logic [POS_W-1:0] bit_pos,
    input logic [7:0]       status_o,
    input logic             irq_o,
    input logic [CTL_W-1:0] ctl_o,
    input logic             sda_drive_o,
    input logic             scl_drive_o,
    input logic             go_idle_o,
    input logic             stop_gen_o
);
    assert_idle_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> status_o == 8'hF8);

    assert_midframe_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_any && mid_frame && active_i) |=> (irq_o && status_o == 8'h00));

    assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos < POS_W'(FRAME_BITS));

    assert_recover_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go_idle_o |-> (!irq_o && !ctl_o[STOP_IDX]));

    assert_recover_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_idle_o |-> (!sda_drive_o && !scl_drive_o));

    assert_no_stop_on_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_idle_o, stop_gen_o}));
endmodule

bind i2c_frame_guard i2c_frame_guard_chk #(
    .CTL_W(CTL_W), .STOP_IDX(STOP_IDX), .FRAME_BITS(FRAME_BITS), .POS_W(POS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active_i),
    .cond_any    (cond_any),
    .mid_frame   (mid_frame),
    .bit_pos     (bit_pos),
    .status_o    (status_o),
    .irq_o       (irq_o),
    .ctl_o       (ctl_o),
    .sda_drive_o (sda_drive_o),
    .scl_drive_o (scl_drive_o),
    .go_idle_o   (go_idle_o),
    .stop_gen_o  (stop_gen_o)
);

// File: tb/i2c_frame_guard_tb_top.sv
module i2c_frame_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, active = 1'b0;
    logic       sda_req = 1'b0, scl_req = 1'b0;
    logic       eng_evt = 1'b0;
    logic [7:0] eng_code = 8'h00;
    logic       ctl_wr = 1'b0, flag_w1 = 1'b0;
    logic [2:0] ctl_wdata = 3'b000;
    logic [7:0] status;
    logic       irq, sda_drv, scl_drv, go_idle, stop_gen;
    logic [2:0] ctl;
    int         errors = 0, checks = 0;
    logic       seen_idle, seen_stop;

    always #2 clk = ~clk;

    i2c_frame_guard dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .active_i(active),
        .sda_req_i(sda_req), .scl_req_i(scl_req), .eng_evt_i(eng_evt),
        .eng_code_i(eng_code), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
        .flag_w1_i(flag_w1), .status_o(status), .irq_o(irq), .ctl_o(ctl),
        .sda_drive_o(sda_drv), .scl_drive_o(scl_drv), .go_idle_o(go_idle),
        .stop_gen_o(stop_gen)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic c, input logic d);
        scl = c;
        sda = d;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [2:0] v, input logic w1);
        ctl_wr = 1'b1; ctl_wdata = v; flag_w1 = w1;
        @(posedge clk);
        @(negedge clk);
        seen_idle = go_idle;
        seen_stop = stop_gen;
        ctl_wr = 1'b0; flag_w1 = 1'b0;
    endtask

    task automatic open_frame(input int nbits);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
        for (int i = 0; i < nbits; i++) begin
            bus(1'b0, i[0]);
            bus(1'b1, i[0]);
            bus(1'b0, i[0]);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 / R1 reset state
        chk(status == 8'hF8, "R1 reset status", status, 8'hF8);
        chk(!irq && ctl == 3'b000, "R10 reset flag/ctl", {irq, ctl}, 0);
        rst_n = 1'b1;
        sda_req = 1'b1; scl_req = 1'b1;
        @(negedge clk);
        chk(!sda_drv && !scl_drv, "R8 released after reset", {sda_drv, scl_drv}, 0);
        chk(!go_idle && !stop_gen, "R10 pulses low", {go_idle, stop_gen}, 0);

        // R2/R3/R4 sweep: condition kind x completed bits x active
        for (int kind = 0; kind < 2; kind++) begin
            for (int k = 0; k <= 9; k++) begin
                for (int a = 0; a < 2; a++) begin
                    logic exp_err;
                    active = a[0];
                    exp_err = a[0] && (k >= 1) && (k <= 8);
                    open_frame(k);
                    bus(1'b0, kind == 0);
                    bus(1'b1, kind == 0);
                    bus(1'b1, kind != 0);
                    chk(irq == exp_err, exp_err ? "R2 error flag" : "R3 R4 legal flag",
                        irq, exp_err);
                    chk(status == (exp_err ? 8'h00 : 8'hF8), "R2 R3 status",
                        status, exp_err ? 8'h00 : 8'hF8);
                    if (irq) host_wr(3'b001, 1'b1);
                    if (kind == 0) bus(1'b1, 1'b1);
                end
            end
        end

        // R3: STOP with no frame open
        active = 1'b1;
        bus(1'b0, 1'b0); bus(1'b1, 1'b0); bus(1'b1, 1'b1);
        chk(!irq, "R3 stop outside frame", irq, 0);

        // R8 baseline: requests pass through after active rises
        active = 1'b0; @(negedge clk); active = 1'b1;
        repeat (2) @(negedge clk);
        chk(sda_drv && scl_drv, "R8 requests pass", {sda_drv, scl_drv}, 3);

        // R7/R8/R9 recovery
        host_wr(3'b110, 1'b0);
        open_frame(3);
        bus(1'b0, 1'b1); bus(1'b1, 1'b1); bus(1'b1, 1'b0);
        chk(irq && status == 8'h00, "R2 error before recovery", status, 0);
        host_wr(3'b101, 1'b1);
        chk(seen_idle, "R7 go_idle pulse", seen_idle, 1);
        chk(!seen_stop, "R9 no stop on recovery", seen_stop, 0);
        chk(ctl == 3'b100, "R7 ctl after recovery", ctl, 3'b100);
        chk(!irq && status == 8'hF8, "R7 R1 flag cleared", status, 8'hF8);
        chk(!sda_drv && !scl_drv, "R8 lines released", {sda_drv, scl_drv}, 0);
        @(negedge clk);
        chk(!go_idle, "R7 pulse one cycle", go_idle, 0);
        repeat (4) @(negedge clk);
        chk(!sda_drv && !scl_drv, "R8 stays released", {sda_drv, scl_drv}, 0);
        active = 1'b0; @(negedge clk); active = 1'b1;
        repeat (2) @(negedge clk);
        chk(sda_drv && scl_drv, "R8 re-enabled on active rise", {sda_drv, scl_drv}, 3);
        bus(1'b1, 1'b1);

        // R5/R6/R9 engine event path
        eng_code = 8'h28; eng_evt = 1'b1; @(negedge clk); eng_evt = 1'b0;
        chk(irq && status == 8'h28, "R5 engine code", status, 8'h28);
        host_wr(3'b000, 1'b0);
        chk(irq, "R6 write zero keeps flag", irq, 1);
        host_wr(3'b001, 1'b1);
        chk(seen_stop && !seen_idle, "R9 stop_gen on normal clear",
            {seen_idle, seen_stop}, 1);
        chk(!irq && ctl == 3'b001, "R6 flag cleared ctl kept", {irq, ctl}, 1);

        // R5/R6 precedence: bus error coincides with a clear write
        eng_code = 8'h40; eng_evt = 1'b1; @(negedge clk); eng_evt = 1'b0;
        open_frame(5);
        bus(1'b0, 1'b1); bus(1'b1, 1'b1);
        sda = 1'b0; ctl_wr = 1'b1; ctl_wdata = 3'b000; flag_w1 = 1'b1;
        @(posedge clk); @(negedge clk);
        ctl_wr = 1'b0; flag_w1 = 1'b0;
        chk(irq && status == 8'h00, "R5 R6 error wins over clear", status, 8'h00);
        host_wr(3'b001, 1'b1);
        chk(!irq, "R7 recovery after precedence", irq, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule